// File: doc/BRIEF.md
# Cascaded Low-Power Match Timer

This block is a three-counter timer that runs in a low-frequency domain. The domain is modelled as one clock plus a tick enable that is high for one cycle per low-frequency period. Counters 0 and 1 are 16-bit up-counters, each with its own compare value and a clear-on-compare option. Counter 1 can be chained behind counter 0 so that the pair forms a 32-bit timebase: a counter 0 compare hit is queued and bumps counter 1 on the following tick. Counter 2 is a free-running 32-bit counter. It raises an event every time a software-selected bit of its value changes, whether that bit rises or falls.

Software reaches the block through a flat register port: a single-cycle write strobe with address and data, and a combinational read. Nothing on this port streams, so it has no valid/ready handshake and no back-pressure. Software can enable the counters, request counter resets, load compare values, choose the watched bit, and read, mask and clear the per-counter event flags. It can also hand the block a delay and let the block compute the watched bit itself. A lock flag freezes the configuration registers while the flag and mask registers stay writable. A single level interrupt output is the OR of the flagged and unmasked events.

Top module: `lp_match_timer`

## Requirements
- R1: After reset, all counters, the control register, the watched-bit select, the flags, the mask and the lock read 0, both compare registers read 16'hFFFF, and irq is 0.
- R2: An enabled counter steps by one on each tick. A disabled counter holds its value and never sets its flag. Enabling a counter keeps its value. Control register (address 0) bits: bit0/1/2 enable counter 0/1/2, bit3 clear-on-compare for counter 0, bit4 clear-on-compare for counter 1, bit5 chains counter 1 behind counter 0.
- R3: With clear-on-compare set, a counter 0 step taken while it equals its compare value (address 1) loads 0. Without it, the counter keeps counting past the compare value.
- R4: With chaining on, counter 1 steps once per counter 0 compare hit, on the next tick after the hit. The queued step survives idle cycles with no tick. With chaining off, counter 1 steps on every tick.
- R5: With its clear-on-compare set, a counter 1 step taken while it equals its compare value (address 2) loads 0.
- R6: The flag bit n of counters 0 and 1 sets on the step that makes counter n equal its compare value.
- R7: Counter 2 sets flag bit 2 on every step in which the watched bit (address 3, 5 bits) changes, on both 0-to-1 and 1-to-0.
- R8: Writing a delay d to address 8 loads the watched-bit select with the index of the highest set bit of c XOR (c + max(d,3)), where c is the current counter 2 value.
- R9: Writing 1 to bit n of address 4 clears counter n on the third tick after the write. The counter keeps counting on the two ticks before that.
- R10: Flags (address 5) use bit n for counter n and clear when 1 is written there. A flag sets even while masked. irq is high exactly when some flag bit and its mask bit (address 6) are both 1.
- R11: While the lock (address 7, bit0) is 1, writes to addresses 0, 1, 2, 3, 4 and 8 are ignored. Writes to the flags, mask and lock registers still take effect.
- R12: Counters 0, 1 and 2 read at addresses 9, 10 and 11, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | One-cycle low-frequency tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| irq | output | 1 | Level interrupt, OR of flags and mask |

## Verification
If the chaining stage is wrong, counter 1 reads one tick early or late, or it loses a queued step across a tickless gap. The check after exactly the fourth and fifth tick of a 4-tick period catches this. A bad compare or clear-on-compare path shows up in the count read on the very tick it wraps, and the flag set on that same tick lands one read later. A wrong watched-bit tap or a wrong delay-to-bit mapping shows at once in the select readback and in the flag after the crossing tick. The same goes for a lock that leaks, which shows on the next readback.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int ADDR_W = 4;
  localparam int NCTR   = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 4'd0,
    A_MATCH0 = 4'd1,
    A_MATCH1 = 4'd2,
    A_TOGSEL = 4'd3,
    A_RESET  = 4'd4,
    A_STATUS = 4'd5,
    A_MASK   = 4'd6,
    A_LOCK   = 4'd7,
    A_DELAY  = 4'd8,
    A_COUNT0 = 4'd9,
    A_COUNT1 = 4'd10,
    A_COUNT2 = 4'd11
  } reg_addr_e;

  typedef struct packed {
    logic chain;
    logic clr1;
    logic clr0;
    logic en2;
    logic en1;
    logic en0;
  } ctrl_t;
endpackage

// File: rtl/lpt_match_ctr.sv
module lpt_match_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         sw_clr,
  input  logic         clr_on_match,
  input  logic [W-1:0] match,
  output logic [W-1:0] count,
  output logic         at_match,
  output logic         arrive
);
  logic [W-1:0] nxt;

  always_comb begin
    if (clr_on_match && (count == match)) nxt = '0;
    else                                  nxt = count + W'(1);
  end

  assign at_match = step && (count == match);
  assign arrive   = step && !sw_clr && (nxt == match);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (sw_clr) count <= '0;
    else if (step)   count <= nxt;
  end

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !sw_clr) |=> $stable(count));

  a_r3_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !sw_clr && clr_on_match && (count == match)) |=> (count == '0));
endmodule

// File: rtl/lpt_toggle_ctr.sv
module lpt_toggle_ctr #(
  parameter int W     = 32,
  parameter int SEL_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             sw_clr,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     count,
  output logic             flip
);
  logic [W-1:0] changed;

  assign changed = count ^ (count + W'(1));
  assign flip    = step && !sw_clr && changed[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (sw_clr) count <= '0;
    else if (step)   count <= count + W'(1);
  end

  a_r7_free_run_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !sw_clr) |=> (count == $past(count) + W'(1)));
endmodule

// File: rtl/lpt_rst_delay.sv
module lpt_rst_delay #(
  parameter int TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic tick,
  output logic fire
);
  localparam int CW = $clog2(TICKS + 1);
  logic [CW-1:0] left;

  assign fire = tick && !req && (left == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   left <= '0;
    else if (req)                 left <= CW'(TICKS);
    else if (tick && left != '0)  left <= left - CW'(1);
  end

  a_r9_no_fire_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (left == '0 && !req) |=> !fire);
endmodule

// File: rtl/lpt_regs.sv
module lpt_regs
  import lpt_pkg::*;
#(
  parameter int C_W     = 16,
  parameter int T_W     = 32,
  parameter int SEL_W   = 5,
  parameter int MIN_DLY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [T_W-1:0]    wr_data,
  input  logic [T_W-1:0]    cnt2,
  input  logic [NCTR-1:0]   set_evt,
  output ctrl_t             ctrl,
  output logic [C_W-1:0]    match0,
  output logic [C_W-1:0]    match1,
  output logic [SEL_W-1:0]  togsel,
  output logic [NCTR-1:0]   rst_req,
  output logic [NCTR-1:0]   status,
  output logic [NCTR-1:0]   mask,
  output logic              lock,
  output logic              irq
);
  logic              cfg_ok;
  logic [NCTR-1:0]   clr_bits;
  logic [T_W-1:0]    dly;
  logic [T_W-1:0]    span;
  logic [SEL_W-1:0]  span_top;

  function automatic logic [SEL_W-1:0] top_bit(input logic [T_W-1:0] v);
    logic [SEL_W-1:0] r;
    r = '0;
    for (int i = 0; i < T_W; i++) begin
      if (v[i]) r = SEL_W'(i);
    end
    return r;
  endfunction

  assign cfg_ok   = wr_en && !lock;
  assign clr_bits = (wr_en && wr_addr == A_STATUS) ? wr_data[NCTR-1:0] : '0;
  assign rst_req  = (cfg_ok && wr_addr == A_RESET) ? wr_data[NCTR-1:0] : '0;
  assign dly      = (wr_data < T_W'(MIN_DLY)) ? T_W'(MIN_DLY) : wr_data;
  assign span     = cnt2 ^ (cnt2 + dly);
  assign span_top = top_bit(span);
  assign irq      = |(status & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      match0 <= '1;
      match1 <= '1;
      togsel <= '0;
      mask   <= '0;
      lock   <= 1'b0;
      status <= '0;
    end else begin
      status <= (status & ~clr_bits) | set_evt;
      if (wr_en && wr_addr == A_MASK) mask <= wr_data[NCTR-1:0];
      if (wr_en && wr_addr == A_LOCK) lock <= wr_data[0];
      if (cfg_ok) begin
        case (wr_addr)
          A_CTRL:   ctrl   <= ctrl_t'(wr_data[$bits(ctrl_t)-1:0]);
          A_MATCH0: match0 <= wr_data[C_W-1:0];
          A_MATCH1: match1 <= wr_data[C_W-1:0];
          A_TOGSEL: togsel <= wr_data[SEL_W-1:0];
          A_DELAY:  togsel <= span_top;
          default: ;
        endcase
      end
    end
  end

  a_r11_lock_holds_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lock) |=> ($stable(ctrl) && $stable(match0) && $stable(match1) && $stable(togsel)));

  for (genvar g = 0; g < NCTR; g++) begin : g_w1c
    a_r10_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_STATUS && wr_data[g] && !set_evt[g]) |=> !status[g]);
    a_r10_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[g] |=> status[g]);
  end
endmodule

// File: rtl/lp_match_timer.sv
module lp_match_timer
  import lpt_pkg::*;
#(
  parameter int C_W       = 16,
  parameter int T_W       = 32,
  parameter int RST_TICKS = 3,
  parameter int MIN_DLY   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [T_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [T_W-1:0]    rd_data,
  output logic              irq
);
  localparam int SEL_W = $clog2(T_W);

  ctrl_t               ctrl;
  logic [C_W-1:0]      match0, match1;
  logic [SEL_W-1:0]    togsel;
  logic [NCTR-1:0]     rst_req, rst_fire, status, mask, set_evt;
  logic                lock;
  logic [1:0][C_W-1:0] cnt, cmp;
  logic [1:0]          step, clr_en, at_match, arrive;
  logic [T_W-1:0]      cnt2;
  logic                flip2, chain_pend;

  lpt_regs #(.C_W(C_W), .T_W(T_W), .SEL_W(SEL_W), .MIN_DLY(MIN_DLY)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt2(cnt2), .set_evt(set_evt), .ctrl(ctrl), .match0(match0), .match1(match1),
    .togsel(togsel), .rst_req(rst_req), .status(status), .mask(mask), .lock(lock),
    .irq(irq)
  );

  for (genvar g = 0; g < NCTR; g++) begin : g_rst
    lpt_rst_delay #(.TICKS(RST_TICKS)) u_dly (
      .clk(clk), .rst_n(rst_n), .req(rst_req[g]), .tick(tick), .fire(rst_fire[g])
    );
  end

  assign step[0]   = tick && ctrl.en0;
  assign step[1]   = tick && ctrl.en1 && (ctrl.chain ? chain_pend : 1'b1);
  assign clr_en[0] = ctrl.clr0;
  assign clr_en[1] = ctrl.clr1;
  assign cmp[0]    = match0;
  assign cmp[1]    = match1;

  for (genvar g = 0; g < 2; g++) begin : g_ctr
    lpt_match_ctr #(.W(C_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .step(step[g]), .sw_clr(rst_fire[g]),
      .clr_on_match(clr_en[g]), .match(cmp[g]), .count(cnt[g]),
      .at_match(at_match[g]), .arrive(arrive[g])
    );
  end

  lpt_toggle_ctr #(.W(T_W), .SEL_W(SEL_W)) u_free (
    .clk(clk), .rst_n(rst_n), .step(tick && ctrl.en2), .sw_clr(rst_fire[2]),
    .sel(togsel), .count(cnt2), .flip(flip2)
  );

  assign set_evt = {flip2, arrive[1], arrive[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    chain_pend <= 1'b0;
    else if (tick) chain_pend <= at_match[0] && ctrl.chain;
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:   rd_data = T_W'(ctrl);
      A_MATCH0: rd_data = T_W'(match0);
      A_MATCH1: rd_data = T_W'(match1);
      A_TOGSEL: rd_data = T_W'(togsel);
      A_STATUS: rd_data = T_W'(status);
      A_MASK:   rd_data = T_W'(mask);
      A_LOCK:   rd_data = T_W'(lock);
      A_COUNT0: rd_data = T_W'(cnt[0]);
      A_COUNT1: rd_data = T_W'(cnt[1]);
      A_COUNT2: rd_data = cnt2;
      default:  rd_data = '0;
    endcase
  end

  a_r4_chain_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ctrl.chain && !chain_pend && !rst_fire[1]) |=> $stable(cnt[1]));

  a_r4_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(chain_pend));

  a_r5_c1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (at_match[1] && ctrl.clr1 && !rst_fire[1]) |=> (cnt[1] == '0));

  a_r2_disabled_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.en0 && !(wr_en && wr_addr == A_STATUS)) |=> (status[0] == $past(status[0])));
endmodule

// File: tb/tb_lp_match_timer.sv
module tb_lp_match_timer;
  import lpt_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  localparam int IRQ_PSEUDO = 99;

  int          q_addr[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  lp_match_timer dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  // monitor: pops expected items and compares mid-cycle
  always begin
    @(negedge clk);
    #2;
    while (q_addr.size() > 0) begin
      int          a;
      logic [31:0] e, got;
      string       t;
      a = q_addr.pop_front();
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      if (a != IRQ_PSEUDO) rd_addr = a[3:0];
      #1;
      got = (a == IRQ_PSEUDO) ? {31'b0, irq} : rd_data;
      total++;
      if (got !== e) begin
        bad++;
        $display("FAIL %s addr=%0d actual=%0h expected=%0h", t, a, got, e);
      end
    end
  end

  task automatic expect_reg(input int a, input logic [31:0] e, input string t);
    q_addr.push_back(a);
    q_exp.push_back(e);
    q_tag.push_back(t);
    @(negedge clk);
  endtask

  task automatic wr(input reg_addr_e a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    expect_reg(A_CTRL,   32'h0,    "R1 ctrl");
    expect_reg(A_MATCH0, 32'hFFFF, "R1 match0");
    expect_reg(A_MATCH1, 32'hFFFF, "R1 match1");
    expect_reg(A_TOGSEL, 32'h0,    "R1 togsel");
    expect_reg(A_COUNT2, 32'h0,    "R1 count2");
    expect_reg(A_STATUS, 32'h0,    "R1 status");
    expect_reg(IRQ_PSEUDO, 32'h0,  "R1 irq");

    // R2 disabled counters hold, no flag
    ticks(5);
    expect_reg(A_COUNT0, 32'h0, "R2 disabled hold");
    expect_reg(A_STATUS, 32'h0, "R2 disabled no flag");

    // R2/R6 counter 0 counting and compare flag
    wr(A_MATCH0, 32'd4);
    wr(A_CTRL, 32'h01);
    ticks(6);
    expect_reg(A_COUNT0, 32'd6, "R2 count0 steps");
    expect_reg(A_STATUS, 32'h1, "R6 flag0 at compare");
    expect_reg(IRQ_PSEUDO, 32'h0, "R10 masked flag no irq");
    wr(A_CTRL, 32'h00);
    ticks(3);
    expect_reg(A_COUNT0, 32'd6, "R2 hold after disable");
    wr(A_CTRL, 32'h01);
    expect_reg(A_COUNT0, 32'd6, "R2 enable keeps value");
    ticks(1);
    expect_reg(A_COUNT0, 32'd7, "R2 resumes");
    wr(A_MASK, 32'h1);
    expect_reg(IRQ_PSEUDO, 32'h1, "R10 irq on unmasked flag");
    wr(A_STATUS, 32'h1);
    expect_reg(A_STATUS, 32'h0, "R10 w1c");
    expect_reg(IRQ_PSEUDO, 32'h0, "R10 irq drops");

    // R3 clear on compare for counter 0
    do_reset();
    wr(A_MATCH0, 32'd4);
    wr(A_CTRL, 32'h09);
    ticks(7);
    expect_reg(A_COUNT0, 32'd2, "R3 wrap at compare");

    // R4/R6 chaining
    do_reset();
    wr(A_MATCH0, 32'd3);
    wr(A_MATCH1, 32'd2);
    wr(A_CTRL, 32'h2B);
    ticks(4);
    expect_reg(A_COUNT1, 32'd0, "R4 chain step delayed");
    expect_reg(A_COUNT1, 32'd0, "R4 pending held without tick");
    ticks(1);
    expect_reg(A_COUNT1, 32'd1, "R4 chain step next tick");
    ticks(3);
    expect_reg(A_STATUS, 32'h1, "R6 flag1 not yet");
    ticks(1);
    expect_reg(A_COUNT1, 32'd2, "R4 second chain step");
    expect_reg(A_STATUS, 32'h3, "R6 flag1 at compare");

    // R5 counter 1 clear on compare, unchained
    do_reset();
    wr(A_MATCH1, 32'd3);
    wr(A_CTRL, 32'h12);
    ticks(3);
    expect_reg(A_COUNT1, 32'd3, "R4 unchained steps each tick");
    expect_reg(A_STATUS, 32'h2, "R6 flag1");
    ticks(1);
    expect_reg(A_COUNT1, 32'd0, "R5 wrap");
    ticks(1);
    expect_reg(A_COUNT1, 32'd1, "R5 after wrap");

    // R7 watched bit both edges
    do_reset();
    wr(A_TOGSEL, 32'd2);
    wr(A_CTRL, 32'h04);
    ticks(3);
    expect_reg(A_STATUS, 32'h0, "R7 no change yet");
    ticks(1);
    expect_reg(A_STATUS, 32'h4, "R7 rise");
    wr(A_STATUS, 32'h4);
    ticks(3);
    expect_reg(A_STATUS, 32'h0, "R7 quiet");
    ticks(1);
    expect_reg(A_COUNT2, 32'd8, "R12 count2");
    expect_reg(A_STATUS, 32'h4, "R7 fall");

    // R8 delay to watched bit
    do_reset();
    wr(A_CTRL, 32'h04);
    ticks(5);
    wr(A_DELAY, 32'd3);
    expect_reg(A_TOGSEL, 32'd3, "R8 d=3");
    wr(A_TOGSEL, 32'd0);
    wr(A_DELAY, 32'd1);
    expect_reg(A_TOGSEL, 32'd3, "R8 clamp d=1");
    wr(A_DELAY, 32'd256);
    expect_reg(A_TOGSEL, 32'd8, "R8 d=256");

    // R9 delayed software reset
    do_reset();
    wr(A_CTRL, 32'h01);
    ticks(10);
    wr(A_RESET, 32'h1);
    ticks(2);
    expect_reg(A_COUNT0, 32'd12, "R9 counting before reset");
    ticks(1);
    expect_reg(A_COUNT0, 32'd0, "R9 cleared third tick");
    ticks(1);
    expect_reg(A_COUNT0, 32'd1, "R9 after reset");

    // R11 lock
    do_reset();
    wr(A_CTRL, 32'h04);
    ticks(1);
    expect_reg(A_STATUS, 32'h4, "R7 bit0 toggles");
    wr(A_LOCK, 32'h1);
    wr(A_CTRL, 32'h00);
    expect_reg(A_CTRL, 32'h04, "R11 ctrl ignored");
    wr(A_MATCH0, 32'd5);
    expect_reg(A_MATCH0, 32'hFFFF, "R11 match ignored");
    wr(A_TOGSEL, 32'd7);
    expect_reg(A_TOGSEL, 32'd0, "R11 togsel ignored");
    wr(A_STATUS, 32'h4);
    expect_reg(A_STATUS, 32'h0, "R11 w1c accepted");
    wr(A_MASK, 32'h4);
    expect_reg(A_MASK, 32'h4, "R11 mask accepted");
    wr(A_RESET, 32'h4);
    ticks(3);
    expect_reg(A_COUNT2, 32'd4, "R11 reset ignored");
    expect_reg(IRQ_PSEUDO, 32'h1, "R10 irq from counter 2");
    wr(A_LOCK, 32'h0);
    wr(A_CTRL, 32'h00);
    expect_reg(A_CTRL, 32'h00, "R11 unlock accepts");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule